// File: doc/BRIEF.md
# Multi-channel sampled input noise filter

This block cleans up a group of asynchronous external pins (trigger, capture and encoder lines of a timer) before they reach the logic that uses them. Each pin is first brought onto the main clock through a short synchronizer chain. All pins then share one voting filter. On every pulse of a sampling strobe, the filter takes a sample of each pin. A filtered line takes a new level only once a fixed number of consecutive samples agree on that level. When filtering is switched off, the synchronized level goes straight through.

The strobe comes from a prescaler on the main clock. A small control register selects the prescaler rate and holds the enable bit. After any write to these fields, the prescaler starts again from zero. A settle flag then stays low until enough strobes have passed to refill the sample history. A one-cycle rise pulse and a one-cycle fall pulse are produced for every output line, and both are held back while the settle flag is low.

Top module: `pin_deglitch_bank`

## Requirements
- R1: The control register resets to 0x00. Bit 7 holds the filter enable and bits 2..0 hold the rate select. A byte write (`wr_byte`) loads both fields from `wr_data`, and `rd_data` returns them with bits 6..3 always 0.
- R2: A bit write (`wr_bit`) sets register bit `bit_idx` to `bit_val` when the index is 7 or is in 0..2. Any other index leaves the register unchanged. When both write strobes are high, the byte write wins.
- R3: Rate select 0 gives a strobe on every clock. Codes 1, 2, 3, 4 and 5 give one strobe every 4, 8, 16, 32 and 64 clocks.
- R4: Every pin passes through a two-flop synchronizer. With the enable bit at 0, `filt_out` follows each pin two clocks later.
- R5: With the enable bit at 1, an output moves to a new level only on a strobe at which the last three samples, the current one included, all show that level. A level seen on only one or two consecutive strobes never reaches the output.
- R6: Select codes 6 and 7 stop the strobe. While the enable bit is set, the filtered outputs then keep their values.
- R7: Any write that touches the enable bit or the select field clears the prescaler, so the first strobe comes one full new period after the write.
- R8: `ready` is low after reset and after every write that touches the enable bit or the select field. It rises only after three strobes have occurred since then.
- R9: `rise_pulse[i]` and `fall_pulse[i]` go high for one clock after `filt_out[i]` goes up or down, and stay low while `ready` is low.
- R10: All five channels use the same settings, and the data of each channel is filtered independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_byte | input | 1 | Load the whole control register from `wr_data` |
| wr_data | input | 8 | Byte write data |
| wr_bit | input | 1 | Write a single register bit |
| bit_idx | input | 3 | Index of the bit written by `wr_bit` |
| bit_val | input | 1 | Value written by `wr_bit` |
| rd_data | output | 8 | Current control register contents |
| pin_in | input | 5 | Raw asynchronous pins |
| filt_out | output | 5 | Filtered (or synchronized) levels |
| rise_pulse | output | 5 | One-clock pulse on an upward change of `filt_out` |
| fall_pulse | output | 5 | One-clock pulse on a downward change of `filt_out` |
| ready | output | 1 | The filter has seen three strobes since the last setting change |

## Verification
A prescaler count that is off by one shows up in the filtered outputs as a shift of one or more clocks in when each change appears. It also decides which short pulses get through, so it becomes visible within a few sampling periods. A wrong sample history or agreement rule shows up at the first pulse that lasts two or three strobes. A wrong settle count shows up directly on `ready`, and on edge pulses that appear or vanish in the cycles right after a write. A reference model in the bench is updated on every clock and compared with every output on every cycle, so any such difference is reported in the cycle it first reaches a port.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

   // Number of main clocks between strobes for a rate code.
   // Code 0 -> 1 clock, code k>0 -> 2^(k+1) clocks.
   function automatic int unsigned period_of(input int unsigned code);
      return (code == 0) ? 32'd1 : (32'd1 << (code + 1));
   endfunction

endpackage

// File: rtl/dgf_ctrl_reg.sv
module dgf_ctrl_reg #(
   parameter int REG_W  = 8,
   parameter int SEL_W  = 3,
   parameter int EN_POS = 7,
   parameter int IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte,
   input  logic [REG_W-1:0] wr_data,
   input  logic             wr_bit,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   output logic             en,
   output logic [SEL_W-1:0] sel,
   output logic             cfg_hit,
   output logic [REG_W-1:0] rd_data
);

   localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'(1) << EN_POS) | REG_W'((1 << SEL_W) - 1);

   logic             en_q, en_d;
   logic [SEL_W-1:0] sel_q, sel_d;
   logic             hit_c;
   logic             unused_pad;

   assign unused_pad = ^(wr_data & ~FIELD_MASK);

   always_comb begin
      en_d  = en_q;
      sel_d = sel_q;
      hit_c = 1'b0;
      if (wr_byte) begin
         en_d  = wr_data[EN_POS];
         sel_d = wr_data[SEL_W-1:0];
         hit_c = 1'b1;
      end else if (wr_bit) begin
         if (int'(bit_idx) == EN_POS) begin
            en_d  = bit_val;
            hit_c = 1'b1;
         end
         for (int b = 0; b < SEL_W; b++) begin
            if (int'(bit_idx) == b) begin
               sel_d[b] = bit_val;
               hit_c    = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else begin
         en_q  <= en_d;
         sel_q <= sel_d;
      end
   end

   always_comb begin
      rd_data                = '0;
      rd_data[EN_POS]        = en_q;
      rd_data[SEL_W-1:0]     = sel_q;
   end

   assign en      = en_q;
   assign sel     = sel_q;
   assign cfg_hit = hit_c;

   // R1: a byte write lands in both fields on the next cycle
   a_r1_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte |=> (rd_data[EN_POS] == $past(wr_data[EN_POS]))
                  && (rd_data[SEL_W-1:0] == $past(wr_data[SEL_W-1:0])));

   // R2: a bit write outside the fields leaves the register as it was
   a_r2_ignored_index: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bit && !wr_byte && int'(bit_idx) != EN_POS && int'(bit_idx) >= SEL_W)
      |=> $stable(rd_data));

endmodule

// File: rtl/dgf_strobe_gen.sv
module dgf_strobe_gen #(
   parameter int SEL_W     = 3,
   parameter int LAST_CODE = 5,
   parameter int SAMPLES   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             cfg_hit,
   output logic             strobe,
   output logic             ready
);

   localparam int CNT_W = LAST_CODE + 1;
   localparam int SET_W = $clog2(SAMPLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic [SET_W-1:0] settle_q;
   logic             legal;

   assign legal    = (int'(sel) <= LAST_CODE);
   assign last_cnt = CNT_W'(dgf_pkg::period_of(int'(sel)) - 1);
   assign strobe   = legal && (cnt_q == last_cnt) && !cfg_hit;
   assign ready    = (settle_q == SET_W'(SAMPLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cfg_hit || !legal || cnt_q == last_cnt) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_q <= '0;
      end else if (cfg_hit) begin
         settle_q <= '0;
      end else if (strobe && !ready) begin
         settle_q <= settle_q + 1'b1;
      end
   end

   // R7: a setting write restarts the prescaler
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> (cnt_q == '0));

   // R8: a setting write drops the settle flag
   a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> !ready);

   // R8: the settle flag comes up only right after a strobe
   a_r8_ready_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(strobe));

endmodule

// File: rtl/dgf_sync_chain.sv
module dgf_sync_chain #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/dgf_vote_filter.sv
module dgf_vote_filter #(
   parameter int SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic din,
   output logic held
);

   logic [SAMPLES-1:0] hist_q;
   logic [SAMPLES-1:0] hist_nx;
   logic               held_q;

   assign hist_nx = {hist_q[SAMPLES-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         held_q <= 1'b0;
      end else if (strobe) begin
         hist_q <= hist_nx;
         if (&hist_nx)       held_q <= 1'b1;
         else if (~|hist_nx) held_q <= 1'b0;
      end
   end

   assign held = held_q;

   // R5: the held level moves only in the cycle after a strobe
   a_r5_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held_q) |-> $past(strobe));

   // R5: a new held level is backed by a full agreeing history
   a_r5_agreement: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held_q) |-> (hist_q == {SAMPLES{held_q}}));

endmodule

// File: rtl/pin_deglitch_bank.sv
module pin_deglitch_bank #(
   parameter int NUM_CH      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int SAMPLES     = 3,
   parameter int REG_W       = 8,
   parameter int SEL_W       = 3,
   parameter int EN_POS      = 7,
   parameter int LAST_CODE   = 5,
   parameter int IDX_W       = $clog2(REG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_byte,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              wr_bit,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              bit_val,
   output logic [REG_W-1:0]  rd_data,
   input  logic [NUM_CH-1:0] pin_in,
   output logic [NUM_CH-1:0] filt_out,
   output logic [NUM_CH-1:0] rise_pulse,
   output logic [NUM_CH-1:0] fall_pulse,
   output logic              ready
);

   // Elaboration-time parameter checks
   if (NUM_CH < 1)                       $error("NUM_CH must be at least 1");
   if (SYNC_STAGES < 2)                  $error("SYNC_STAGES must be at least 2");
   if (SAMPLES < 2)                      $error("SAMPLES must be at least 2");
   if (EN_POS < SEL_W || EN_POS >= REG_W) $error("EN_POS must sit above the select field");
   if (LAST_CODE >= (1 << SEL_W))        $error("LAST_CODE must fit the select field");
   if ((1 << IDX_W) < REG_W)             $error("IDX_W too narrow for REG_W");

   logic              en;
   logic [SEL_W-1:0]  sel;
   logic              cfg_hit;
   logic              strobe;
   logic [NUM_CH-1:0] sync_lvl;
   logic [NUM_CH-1:0] held_lvl;
   logic [NUM_CH-1:0] prev_q;

   dgf_ctrl_reg #(
      .REG_W (REG_W), .SEL_W (SEL_W), .EN_POS (EN_POS), .IDX_W (IDX_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_byte (wr_byte),
      .wr_data (wr_data),
      .wr_bit  (wr_bit),
      .bit_idx (bit_idx),
      .bit_val (bit_val),
      .en      (en),
      .sel     (sel),
      .cfg_hit (cfg_hit),
      .rd_data (rd_data)
   );

   dgf_strobe_gen #(
      .SEL_W (SEL_W), .LAST_CODE (LAST_CODE), .SAMPLES (SAMPLES)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .cfg_hit (cfg_hit),
      .strobe  (strobe),
      .ready   (ready)
   );

   dgf_sync_chain #(
      .W (NUM_CH), .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (sync_lvl)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      dgf_vote_filter #(
         .SAMPLES (SAMPLES)
      ) u_vote (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (strobe),
         .din    (sync_lvl[ch]),
         .held   (held_lvl[ch])
      );
   end

   assign filt_out = en ? held_lvl : sync_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= filt_out;
   end

   assign rise_pulse = {NUM_CH{ready}} & filt_out & ~prev_q;
   assign fall_pulse = {NUM_CH{ready}} & ~filt_out & prev_q;

   // R9: an edge pulse never lasts two cycles
   a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_pulse & $past(rise_pulse)) == '0) && ((fall_pulse & $past(fall_pulse)) == '0));

   // R6: with a prohibited rate and no write, enabled outputs freeze
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en && int'(sel) > LAST_CODE && !wr_byte && !wr_bit) |=> $stable(filt_out));

endmodule

// File: tb/tb_pin_deglitch_bank.sv
module tb_pin_deglitch_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 5;
   localparam int WATCHDOG   = 100000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_byte = 1'b0;
   logic [7:0]     wr_data = '0;
   logic           wr_bit = 1'b0;
   logic [2:0]     bit_idx = '0;
   logic           bit_val = 1'b0;
   logic [7:0]     rd_data;
   logic [NCH-1:0] pin_in = '0;
   logic [NCH-1:0] filt_out, rise_pulse, fall_pulse;
   logic           ready;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_deglitch_bank dut (
      .clk (clk), .rst_n (rst_n),
      .wr_byte (wr_byte), .wr_data (wr_data),
      .wr_bit (wr_bit), .bit_idx (bit_idx), .bit_val (bit_val),
      .rd_data (rd_data), .pin_in (pin_in),
      .filt_out (filt_out), .rise_pulse (rise_pulse), .fall_pulse (fall_pulse),
      .ready (ready)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit           m_en;
   bit [2:0]     m_sel;
   int           m_cnt, m_settle;
   bit [NCH-1:0] m_s1, m_s2, m_held, m_prev;
   int           m_h [NCH];

   always @(posedge clk or negedge rst_n) begin : model
      bit hit, stb, legal;
      int per;
      if (!rst_n) begin
         m_en = 0; m_sel = 0; m_cnt = 0; m_settle = 0;
         m_s1 = 0; m_s2 = 0; m_held = 0; m_prev = 0;
         for (int c = 0; c < NCH; c++) m_h[c] = 0;
      end else begin
         hit   = wr_byte || (wr_bit && (bit_idx == 3'd7 || bit_idx < 3'd3));
         legal = (m_sel <= 3'd5);
         per   = (m_sel == 0) ? 1 : (1 << (int'(m_sel) + 1));
         stb   = legal && (m_cnt == per - 1) && !hit;
         m_prev = m_en ? m_held : m_s2;
         if (stb) begin
            for (int c = 0; c < NCH; c++) begin
               m_h[c] = ((m_h[c] << 1) | int'(m_s2[c])) & 7;
               if (m_h[c] == 7)      m_held[c] = 1'b1;
               else if (m_h[c] == 0) m_held[c] = 1'b0;
            end
         end
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (hit)                          m_settle = 0;
         else if (stb && m_settle < 3)     m_settle++;
         if (hit || !legal || m_cnt == per - 1) m_cnt = 0;
         else                                   m_cnt++;
         if (wr_byte) begin
            m_en  = wr_data[7];
            m_sel = wr_data[2:0];
         end else if (wr_bit) begin
            if (bit_idx == 3'd7)     m_en = bit_val;
            else if (bit_idx < 3'd3) m_sel[bit_idx] = bit_val;
         end
      end
   end

   // Compare every output on every cycle, away from the active edge
   always @(negedge clk) begin : compare
      bit [NCH-1:0] e_out, e_rise, e_fall;
      bit e_rdy;
      if (rst_n && !done) begin
         e_out  = m_en ? m_held : m_s2;
         e_rdy  = (m_settle == 3);
         e_rise = e_rdy ? (e_out & ~m_prev) : '0;
         e_fall = e_rdy ? (~e_out & m_prev) : '0;
         chk(filt_out == e_out, m_en ? "R5 R3 R7 R10 filt_out" : "R4 R10 filt_out",
             filt_out, e_out);
         chk(ready == e_rdy, "R8 ready", ready, e_rdy);
         chk(rise_pulse == e_rise, "R9 rise_pulse", rise_pulse, e_rise);
         chk(fall_pulse == e_fall, "R9 fall_pulse", fall_pulse, e_fall);
         chk(rd_data == {m_en, 4'b0000, m_sel}, "R1 R2 rd_data", rd_data, {m_en, 4'b0000, m_sel});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic write_byte(input logic [7:0] d);
      @(negedge clk);
      wr_byte = 1'b1; wr_data = d;
      @(negedge clk);
      wr_byte = 1'b0;
   endtask

   task automatic write_bit(input logic [2:0] idx, input logic v);
      @(negedge clk);
      wr_bit = 1'b1; bit_idx = idx; bit_val = v;
      @(negedge clk);
      wr_bit = 1'b0;
   endtask

   task automatic run_random(input int cycles, input int hold);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++)
            if ($urandom_range(hold - 1, 0) == 0) pin_in[c] = ~pin_in[c];
      end
   endtask

   // Pulse on channel 0 lasting w clocks; returns whether filt_out[0] went high
   task automatic pulse_probe(input int w, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < w + 10; i++) begin
         @(negedge clk);
         seen |= filt_out[0];
         pin_in[0] = (i < w);
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      bit seen;
      logic [NCH-1:0] snap;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 R8: reset state before any clock edge out of reset
      chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 8'h00);
      chk(ready == 1'b0, "R8 reset ready", ready, 0);
      chk(filt_out == '0, "R4 reset filt_out", filt_out, 0);

      // R4: plain synchronized pass-through
      run_random(600, 3);

      // R5: strobe every clock, two-sample pulse rejected, three-sample pulse kept
      write_byte(8'h80);
      pin_in = '0;
      repeat (12) @(negedge clk);
      pulse_probe(2, seen);
      chk(seen == 1'b0, "R5 two-sample pulse rejected", seen, 0);
      pulse_probe(3, seen);
      chk(seen == 1'b1, "R5 three-sample pulse kept", seen, 1);
      pulse_probe(1, seen);
      chk(seen == 1'b0, "R5 one-sample pulse rejected", seen, 0);

      // R3 R7 R10: each legal rate with independent channel activity
      write_byte(8'h81); run_random(1500, 10);
      write_byte(8'h82); run_random(1500, 20);
      write_byte(8'h83); run_random(1500, 40);
      write_byte(8'h84); run_random(2500, 80);
      write_byte(8'h85); run_random(4000, 150);

      // R2: bit writes
      write_bit(3'd5, 1'b1);
      @(negedge clk);
      chk(rd_data == 8'h85, "R2 index 5 ignored", rd_data, 8'h85);
      write_bit(3'd2, 1'b0);
      @(negedge clk);
      chk(rd_data == 8'h81, "R2 bit 2 cleared", rd_data, 8'h81);
      write_bit(3'd7, 1'b0);
      @(negedge clk);
      chk(rd_data == 8'h01, "R2 enable cleared", rd_data, 8'h01);
      run_random(300, 6);
      write_bit(3'd7, 1'b1);
      run_random(600, 12);

      // R1 R6 R8: prohibited code freezes outputs and keeps ready low
      write_byte(8'hFF);
      @(negedge clk);
      chk(rd_data == 8'h87, "R1 pad bits read zero", rd_data, 8'h87);
      snap = filt_out;
      run_random(80, 2);
      chk(filt_out == snap, "R6 outputs hold under prohibited code", filt_out, snap);
      chk(ready == 1'b0, "R8 ready stays low without strobes", ready, 0);
      write_byte(8'h86);
      run_random(40, 2);
      chk(filt_out == snap, "R6 outputs hold under code 6", filt_out, snap);

      // R7: back to a legal rate
      write_byte(8'h82);
      run_random(1500, 25);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule